// File: doc/BRIEF.md
# DDR3 Power-Up Sequencer (Wishbone Write Master)

This block brings a DDR3 memory out of reset by writing a fixed series of values into the software-control register window of a DDR3 controller. It is a Wishbone write-only master. After `start_i` it drives the control bits and loads the four mode registers in the order the device needs. It then triggers a ZQ calibration and finally passes the memory back to the controller's own hardware path. Between some steps it holds the bus idle for a set number of cycles, so the DRAM timing after mode loads, after calibration and after release is met.

The controller window is word addressed. A command reaches the DRAM indirectly: the sequencer stages the row/column value and the bank, writes the command code, and then writes the issue strobe. The three idle lengths are parameters. One down-counter times all of them. `busy_o` covers the whole run, and `done_o` stays set until the next reset.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_ni` is low, and afterwards until `start_i` is seen high at a rising edge, `wb_cyc_o`, `wb_stb_o`, `wb_we_o`, `busy_o` and `done_o` are all low.
- R2: Every access is a write. `wb_cyc_o`, `wb_stb_o` and `wb_we_o` are high and `wb_sel_o` is all ones. `wb_adr_o` and `wb_dat_o` hold steady from the first cycle of the access until the edge where `wb_ack_i` is sampled high.
- R3: Word addresses: control = 0, command code = 1, issue strobe = 2, DRAM address = 3, bank = 4.
- R4: The run opens with five writes: control 0xE, DRAM address 0, bank 0, control 0xC, control 0xE.
- R5: Each DRAM command is four writes in the fixed order DRAM address, bank, command code, issue strobe. The issue strobe value is 1, and the command code for a mode-register load is 0xF.
- R6: Mode registers load in this order: bank 2 with 0x200, bank 3 with 0x0, bank 1 with 0x6, bank 0 with 0x320.
- R7: After the ack of the last mode-load issue write, the bus stays idle for exactly `WAIT_MR` cycles. Then ZQ calibration is sent as DRAM address 0x400, bank 0, command code 0x3.
- R8: After the ack of the ZQ issue write, the bus stays idle for exactly `WAIT_ZQ` cycles. Then control is written with 0x1. The run has 26 writes in total.
- R9: `busy_o` rises one cycle after `start_i` is taken. `done_o` rises exactly `WAIT_REL` cycles after the ack of the final write. At that point `busy_o` falls, and `done_o` stays high with the bus idle until reset.
- R10: `start_i` has no effect while the run is busy or after it is done: no write is repeated and none is added.
- R11: Between two writes that have no wait step between them, `wb_cyc_o` is low for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins the sequence when idle |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | AW | Word address |
| wb_dat_o | output | DW | Write data |
| wb_sel_o | output | DW/8 | Byte selects |
| wb_ack_i | input | 1 | Slave acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, sticky until reset |

## Verification
The assertions assume the slave raises `wb_ack_i` only while `wb_cyc_o` is high, and only for one cycle per access. They also assume every wait parameter is at least 1. The bench's slave model acknowledges at the falling edge during an active cycle, after a chosen latency. It drops `wb_ack_i` as soon as the cycle closes, so it never acknowledges an idle bus. The run is repeated with zero and with three cycles of ack latency to show that only access length changes, not the idle gaps.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  localparam int NUM_STEPS = 26;
  localparam int STEP_W    = 5;

  localparam logic [2:0] RG_CTRL  = 3'd0;
  localparam logic [2:0] RG_CMD   = 3'd1;
  localparam logic [2:0] RG_ISSUE = 3'd2;
  localparam logic [2:0] RG_ADDR  = 3'd3;
  localparam logic [2:0] RG_BANK  = 3'd4;

  typedef enum logic [1:0] {WT_NONE, WT_MR, WT_ZQ, WT_REL} wait_e;

  typedef struct packed {
    logic [2:0]  rg;
    logic [15:0] val;
    wait_e       wt;
  } step_t;

  function automatic step_t mk(logic [2:0] rg, logic [15:0] val, wait_e wt);
    step_t s;
    s.rg  = rg;
    s.val = val;
    s.wt  = wt;
    return s;
  endfunction

  // steps 5..24: five 4-write command groups (MR2, MR3, MR1, MR0, ZQ)
  function automatic step_t step_of(logic [STEP_W-1:0] idx);
    int          i, g, k;
    logic [15:0] a, b, c;
    wait_e       w;
    i = int'(idx);
    if (i < 5) begin
      case (i)
        0:       return mk(RG_CTRL, 16'hE, WT_NONE);
        1:       return mk(RG_ADDR, 16'h0, WT_NONE);
        2:       return mk(RG_BANK, 16'h0, WT_NONE);
        3:       return mk(RG_CTRL, 16'hC, WT_NONE);
        default: return mk(RG_CTRL, 16'hE, WT_NONE);
      endcase
    end
    if (i >= 25) return mk(RG_CTRL, 16'h1, WT_REL);
    g = (i - 5) / 4;
    k = (i - 5) % 4;
    c = 16'hF;
    w = WT_NONE;
    case (g)
      0:       begin a = 16'h200; b = 16'd2; end
      1:       begin a = 16'h000; b = 16'd3; end
      2:       begin a = 16'h006; b = 16'd1; end
      3:       begin a = 16'h320; b = 16'd0; w = WT_MR; end
      default: begin a = 16'h400; b = 16'd0; c = 16'h3; w = WT_ZQ; end
    endcase
    case (k)
      0:       return mk(RG_ADDR, a, WT_NONE);
      1:       return mk(RG_BANK, b, WT_NONE);
      2:       return mk(RG_CMD, c, WT_NONE);
      default: return mk(RG_ISSUE, 16'h1, w);
    endcase
  endfunction

endpackage

// File: rtl/ddr_init_rom.sv
module ddr_init_rom
  import ddr_init_pkg::*;
#(
  parameter int AW = 30,
  parameter int DW = 32
) (
  input  logic [STEP_W-1:0] step_i,
  output logic [AW-1:0]     adr_o,
  output logic [DW-1:0]     dat_o,
  output wait_e             wt_o
);
  step_t s;

  always_comb begin
    s     = step_of(step_i);
    adr_o = AW'(s.rg);
    dat_o = DW'(s.val);
    wt_o  = s.wt;
  end
endmodule

// File: rtl/ddr_wb_wr.sv
module ddr_wb_wr #(
  parameter int AW = 30,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] adr_i,
  input  logic [DW-1:0] dat_i,
  output logic          cyc_o,
  output logic          stb_o,
  output logic          we_o,
  output logic [AW-1:0] adr_o,
  output logic [DW-1:0] dat_o,
  output logic [SW-1:0] sel_o,
  input  logic          ack_i,
  output logic          acc_o
);
  logic          cyc_q;
  logic [AW-1:0] adr_q;
  logic [DW-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= 1'b0;
      adr_q <= '0;
      dat_q <= '0;
    end else if (go_i) begin
      cyc_q <= 1'b1;
      adr_q <= adr_i;
      dat_q <= dat_i;
    end else if (cyc_q && ack_i) begin
      cyc_q <= 1'b0;
    end
  end

  assign cyc_o = cyc_q;
  assign stb_o = cyc_q;
  assign we_o  = cyc_q;
  assign adr_o = adr_q;
  assign dat_o = dat_q;
  assign sel_o = cyc_q ? '1 : '0;
  assign acc_o = cyc_q & ack_i;

  // R2
  xfer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_o && !ack_i |=> cyc_o && $stable(adr_o) && $stable(dat_o));
  // R2
  sel_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_o |-> stb_o && we_o && (sel_o == {SW{1'b1}}));
  // R11
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_o && ack_i |=> !cyc_o);
endmodule

// File: rtl/ddr_wait_tmr.sv
module ddr_wait_tmr #(
  parameter int CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          exp_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign exp_o = (cnt_q == CW'(1));

  // R7
  tmr_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_o && !load_i |=> !exp_o);
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int AW       = 30,
  parameter int DW       = 32,
  parameter int WAIT_MR  = 200,
  parameter int WAIT_ZQ  = 200,
  parameter int WAIT_REL = 2000,
  localparam int SW      = DW / 8,
  localparam int MAXW    = (WAIT_MR > WAIT_ZQ) ?
                           ((WAIT_MR > WAIT_REL) ? WAIT_MR : WAIT_REL) :
                           ((WAIT_ZQ > WAIT_REL) ? WAIT_ZQ : WAIT_REL),
  localparam int CW      = $clog2(MAXW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  output logic          wb_we_o,
  output logic [AW-1:0] wb_adr_o,
  output logic [DW-1:0] wb_dat_o,
  output logic [SW-1:0] wb_sel_o,
  input  logic          wb_ack_i,
  output logic          busy_o,
  output logic          done_o
);
  typedef enum logic [2:0] {ST_IDLE, ST_LAUNCH, ST_XFER, ST_WAIT, ST_DONE} st_e;

  st_e               st_q;
  logic [STEP_W-1:0] step_q;
  logic              final_q;
  logic [AW-1:0]     rom_adr;
  logic [DW-1:0]     rom_dat;
  wait_e             rom_wt;
  logic              go, acc, tmr_exp, tmr_load;
  logic [CW-1:0]     tmr_val;

  ddr_init_rom #(.AW(AW), .DW(DW)) u_rom (
    .step_i (step_q),
    .adr_o  (rom_adr),
    .dat_o  (rom_dat),
    .wt_o   (rom_wt)
  );

  ddr_wb_wr #(.AW(AW), .DW(DW)) u_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .adr_i  (rom_adr),
    .dat_i  (rom_dat),
    .cyc_o  (wb_cyc_o),
    .stb_o  (wb_stb_o),
    .we_o   (wb_we_o),
    .adr_o  (wb_adr_o),
    .dat_o  (wb_dat_o),
    .sel_o  (wb_sel_o),
    .ack_i  (wb_ack_i),
    .acc_o  (acc)
  );

  ddr_wait_tmr #(.CW(CW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .exp_o  (tmr_exp)
  );

  // wait expiry launches the next write directly so the gap is exact
  assign go       = (st_q == ST_LAUNCH) || ((st_q == ST_WAIT) && tmr_exp && !final_q);
  assign tmr_load = (st_q == ST_XFER) && acc && (rom_wt != WT_NONE);

  always_comb begin
    case (rom_wt)
      WT_MR:   tmr_val = CW'(WAIT_MR);
      WT_ZQ:   tmr_val = CW'(WAIT_ZQ);
      WT_REL:  tmr_val = CW'(WAIT_REL);
      default: tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      step_q  <= '0;
      final_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE:   if (start_i) st_q <= ST_LAUNCH;
        ST_LAUNCH: st_q <= ST_XFER;
        ST_XFER: if (acc) begin
          step_q <= step_q + 1'b1;
          if (rom_wt != WT_NONE) begin
            st_q    <= ST_WAIT;
            final_q <= (rom_wt == WT_REL);
          end else begin
            st_q <= ST_LAUNCH;
          end
        end
        ST_WAIT: if (tmr_exp) st_q <= final_q ? ST_DONE : ST_XFER;
        default: st_q <= ST_DONE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done_o = (st_q == ST_DONE);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wb_cyc_o);
  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !busy_o);
  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> busy_o || done_o);
  // R7
  wait_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> !wb_cyc_o);
  // R8
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_cyc_o |-> (int'(step_q) < NUM_STEPS));
endmodule

// File: tb/ddr_init_seq_test.sv
`timescale 1ns/1ps
module ddr_init_seq_test;
  localparam int AW = 30, DW = 32, SW = DW / 8;
  localparam int W_MR = 200, W_ZQ = 200, W_REL = 2000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ack = 1'b0;
  logic cyc, stb, we, busy, done;
  logic [AW-1:0] adr;
  logic [DW-1:0] dat;
  logic [SW-1:0] sel;

  always #2.5 clk = ~clk;

  ddr_init_seq #(.AW(AW), .DW(DW), .WAIT_MR(W_MR), .WAIT_ZQ(W_ZQ), .WAIT_REL(W_REL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we), .wb_adr_o(adr),
    .wb_dat_o(dat), .wb_sel_o(sel), .wb_ack_i(ack),
    .busy_o(busy), .done_o(done)
  );

  typedef struct {
    logic [AW-1:0] adr;
    logic [DW-1:0] dat;
    int            gap;
    string         tag;
    string         gtag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  int lat = 0, wdly = 0, idle_cnt = 0, nwr = 0;
  bit in_xfer = 0, saw_cyc = 0, done_seen = 0;
  logic [AW-1:0] cap_adr;
  logic [DW-1:0] cap_dat;
  int cur_gap = 0;

  task automatic chk(bit ok, string rq, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic push(int a, int d, int g, string t, string gt);
    exp_t e;
    e.adr = AW'(a); e.dat = DW'(d); e.gap = g; e.tag = t; e.gtag = gt;
    sb.push_back(e);
  endtask

  task automatic push_cmd(int a, int b, int c, int g0, string t, string gt);
    push(3, a, g0, t, gt);
    push(4, b, 1, t, "R11");
    push(1, c, 1, "R5", "R11");
    push(2, 1, 1, "R5", "R11");
  endtask

  task automatic load_expected();
    sb.delete();
    push(0, 'hE, -1, "R4", "");
    push(3, 0, 1, "R4", "R11");
    push(4, 0, 1, "R4", "R11");
    push(0, 'hC, 1, "R4", "R11");
    push(0, 'hE, 1, "R4", "R11");
    push_cmd('h200, 2, 'hF, 1, "R6", "R11");
    push_cmd('h000, 3, 'hF, 1, "R6", "R11");
    push_cmd('h006, 1, 'hF, 1, "R6", "R11");
    push_cmd('h320, 0, 'hF, 1, "R6", "R11");
    push_cmd('h400, 0, 'h3, W_MR, "R7", "R7");
    push(0, 'h1, W_ZQ, "R8", "R8");
  endtask

  // monitor + slave model
  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 0; in_xfer = 0; idle_cnt = 0; nwr = 0; done_seen = 0;
    end else begin
      if (cyc) begin
        saw_cyc = 1;
        if (!in_xfer) begin
          in_xfer = 1; cap_adr = adr; cap_dat = dat;
          cur_gap = idle_cnt; idle_cnt = 0; wdly = lat;
        end else begin
          chk(adr == cap_adr && dat == cap_dat, "R2 hold", longint'(adr), longint'(cap_adr));
        end
        if (!ack) begin
          if (wdly == 0) begin
            exp_t e;
            ack = 1;
            nwr++;
            chk(stb && we && sel == {SW{1'b1}}, "R2 strobes", longint'(sel), longint'({SW{1'b1}}));
            if (sb.size() == 0) begin
              chk(0, "R10 extra write", longint'(adr), 0);
            end else begin
              e = sb.pop_front();
              chk(adr == e.adr, {"R3 ", e.tag}, longint'(adr), longint'(e.adr));
              chk(dat == e.dat, e.tag, longint'(dat), longint'(e.dat));
              if (e.gap >= 0) chk(cur_gap == e.gap, e.gtag, cur_gap, e.gap);
            end
          end else wdly--;
        end else begin
          ack = 0;
        end
      end else begin
        ack = 0; in_xfer = 0;
        if (busy) idle_cnt++;
      end
      if (done && !done_seen) begin
        done_seen = 1;
        chk(idle_cnt == W_REL, "R9 release wait", idle_cnt, W_REL);
        chk(nwr == 26, "R8 write count", nwr, 26);
      end
    end
  end

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic run_pass();
    load_expected();
    pulse_start();
    chk(busy == 1, "R9 busy rise", busy, 1);
    repeat (60) @(negedge clk);
    pulse_start(); // R10 mid-run start
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    chk(done == 1, "R9 watchdog", done, 1);
    @(negedge clk);
    chk(sb.size() == 0, "R10 missing writes", sb.size(), 0);
    saw_cyc = 0;
    pulse_start(); // R10 start after done
    repeat (30) @(negedge clk);
    chk(!saw_cyc && done && !busy, "R10 after done", {saw_cyc, done, busy}, 3'b010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cyc && !stb && !we && !busy && !done, "R1 reset", {cyc, busy, done}, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk(!saw_cyc && !busy && !done, "R1 no start", {saw_cyc, busy, done}, 0);
    lat = 0;
    run_pass();
    rst_n = 0;
    @(negedge clk);
    chk(!cyc && !busy && !done, "R1 reset after done", {cyc, busy, done}, 0);
    rst_n = 1;
    lat = 3;
    @(negedge clk);
    run_pass();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule